// File: doc/BRIEF.md
# Converter Sequence Control Unit

This block is the control and status front end of a multi-channel analog-to-digital sequencer. Software programs it over a small synchronous register bus: one register configures the external trigger and the completion interrupt, the other sets the conversion count per sequence, the result FIFO mode and the freeze behaviour. The block passes the decoded count and modes to the sequencer.

An external trigger pin first crosses a two-flop synchronizer. It is then matched against one of four sensitivities: falling edge, rising edge, low level or high level. A match while the sequencer is idle issues a one-cycle start pulse. The sequencer reports the end of a sequence with a completion pulse. That pulse sets a sticky completion flag, which drives the interrupt output when the interrupt is enabled.

Any write to the sequence register cancels the running sequence. The block signals the cancel with an abort pulse and issues no start on account of the write.

Top module: `seq_ctrl_unit`

## Requirements
- R1: In edge mode (trigger config bit 1 = 0), a start pulse lasting one cycle is issued for each selected transition of `extTrig`: bit 0 = 1 selects rising and bit 0 = 0 selects falling. The pulse appears two clock edges after the pin changes and requires trigger enable (bit 2 = 1) and an idle sequencer. Holding the pin steady issues no further starts.
- R2: In level mode (trigger config bit 1 = 1), a start is issued whenever the synchronized pin equals the polarity bit (bit 0), the trigger is enabled and no sequence is running. This includes the cycle right after a completion.
- R3: The trigger config register is at address 0. Bit 4 reads as the completion flag when the interrupt enable (bit 3) is 1 and reads 0 when it is 0. Bits 7..5 read 0.
- R4: `irqOut` is high exactly when the interrupt enable is 1 and the completion flag is set.
- R5: Writing either value to config bit 4 leaves the completion flag unchanged.
- R6: After reset, address 1 reads 0x20, `seqLen` is 4, and address 0, `irqOut`, `seqStart` and `seqAbort` are all 0.
- R7: The sequence register is at address 1. Bits 6..3 form a count field weighted 8, 4, 2, 1, bit 2 is FIFO mode (`fifoEn`) and bits 1..0 are the freeze field (`frzMode`). Bit 7 always reads 0.
- R8: `seqLen` equals the count field for values 1 to 8. A count field of 0, or of 9 or more, gives 8.
- R9: A write to address 1 raises `seqAbort` for the one cycle after the write and ends any running sequence. `seqStart` stays low in the write cycle and in the abort cycle. After the abort, the next trigger match starts a new sequence.
- R10: The completion flag is set by `seqDone` while a sequence runs and is cleared by the next start. A `seqDone` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Write data |
| regWe | input | 1 | Write enable |
| regRdata | output | DATA_W | Read data for `regAddr` (combinational) |
| extTrig | input | 1 | Asynchronous external trigger |
| seqDone | input | 1 | Completion pulse from the sequencer |
| seqStart | output | 1 | Start pulse to the sequencer |
| seqAbort | output | 1 | Abort pulse to the sequencer |
| irqOut | output | 1 | Completion interrupt |
| seqLen | output | $clog2(MAX_LEN+1) | Conversions per sequence |
| fifoEn | output | 1 | Result FIFO mode |
| frzMode | output | 2 | Freeze behaviour field |

## Verification
The hardest situation to reach is a completion pulse that lands after an abort has already cleared the running sequence. Reaching it requires a real sequence to be started by a trigger edge, then cancelled by a sequence-register write, and only then hit by `seqDone`. The stimulus goes through exactly those steps. It then checks that the interrupt stays low and that a fresh edge starts again. Level mode is driven so that a completion and a still-active level coincide, which exercises the back-to-back restart.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

  localparam int unsigned CFG_ADDR = 0;
  localparam int unsigned SEQ_ADDR = 1;
  localparam int unsigned SEQ_BITS = 7;
  localparam logic [SEQ_BITS-1:0] SEQ_RESET = 7'b010_0000;

  typedef struct packed {
    logic trigEn;
    logic lvlSel;
    logic polSel;
    logic irqEn;
  } trigCfg_t;

  typedef struct packed {
    logic seqWrite;
  } dpStrobe_t;

  typedef struct packed {
    logic scf;
  } ctrlStat_t;

endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import seq_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  input  ctrlStat_t         stat,
  output trigCfg_t          cfg,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic [LEN_W-1:0]  seqLen,
  output logic              fifoEn,
  output logic [1:0]        frzMode
);

  logic [SEQ_BITS-1:0] seqReg;
  logic [3:0]          lenField;
  logic                cfgHit, seqHit;
  logic                unusedHigh;

  assign cfgHit     = (regAddr == ADDR_W'(CFG_ADDR));
  assign seqHit     = (regAddr == ADDR_W'(SEQ_ADDR));
  assign unusedHigh = ^regWdata[DATA_W-1:SEQ_BITS];
  assign strobe.seqWrite = regWe && seqHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      seqReg <= SEQ_RESET;
    end else if (regWe) begin
      if (cfgHit) begin
        cfg.polSel <= regWdata[0];
        cfg.lvlSel <= regWdata[1];
        cfg.trigEn <= regWdata[2];
        cfg.irqEn  <= regWdata[3];
      end
      if (seqHit) seqReg <= regWdata[SEQ_BITS-1:0];
    end
  end

  assign lenField = seqReg[6:3];
  assign fifoEn   = seqReg[2];
  assign frzMode  = seqReg[1:0];

  always_comb begin
    if (lenField == 4'd0 || int'(lenField) > MAX_LEN) seqLen = LEN_W'(MAX_LEN);
    else                                               seqLen = LEN_W'(lenField);
  end

  always_comb begin
    regRdata = '0;
    if (cfgHit) begin
      regRdata[3:0] = {cfg.irqEn, cfg.trigEn, cfg.lvlSel, cfg.polSel};
      regRdata[4]   = cfg.irqEn & stat.scf;
    end else if (seqHit) begin
      regRdata[SEQ_BITS-1:0] = seqReg;
    end
  end

  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(seqLen) >= 1) && (int'(seqLen) <= MAX_LEN));

  assert_top_bit_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqHit |-> (regRdata[DATA_W-1] == 1'b0));

endmodule

// File: rtl/seq_trig_ctrl.sv
module seq_trig_ctrl
  import seq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      extTrig,
  input  logic      seqDone,
  input  trigCfg_t  cfg,
  input  dpStrobe_t strobe,
  output ctrlStat_t stat,
  output logic      seqStart,
  output logic      seqAbort,
  output logic      irqOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic trigNow, trigPrev;
  logic edgeHit, levelHit, trigHit;
  logic busy, scf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], extTrig};
      trigPrev <= trigNow;
    end
  end

  assign trigNow  = syncQ[SYNC_STAGES-1];
  assign edgeHit  = cfg.polSel ? (trigNow & ~trigPrev) : (~trigNow & trigPrev);
  assign levelHit = (trigNow == cfg.polSel);
  assign trigHit  = cfg.lvlSel ? levelHit : edgeHit;

  assign seqStart = cfg.trigEn & trigHit & ~busy & ~strobe.seqWrite & ~seqAbort;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      scf      <= 1'b0;
      seqAbort <= 1'b0;
    end else begin
      seqAbort <= strobe.seqWrite;
      if (strobe.seqWrite)  busy <= 1'b0;
      else if (seqStart)    busy <= 1'b1;
      else if (seqDone)     busy <= 1'b0;
      if (seqStart)                                  scf <= 1'b0;
      else if (seqDone && busy && !strobe.seqWrite)  scf <= 1'b1;
    end
  end

  assign stat.scf = scf;
  assign irqOut   = cfg.irqEn & scf;

  assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> busy);

  assert_no_start_on_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqAbort |-> (!seqStart && !busy));

  assert_start_clears_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !irqOut);

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
  import seq_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int MAX_LEN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  input  logic                         regWe,
  output logic [DATA_W-1:0]            regRdata,
  input  logic                         extTrig,
  input  logic                         seqDone,
  output logic                         seqStart,
  output logic                         seqAbort,
  output logic                         irqOut,
  output logic [$clog2(MAX_LEN+1)-1:0] seqLen,
  output logic                         fifoEn,
  output logic [1:0]                   frzMode
);

  trigCfg_t  cfg;
  dpStrobe_t strobe;
  ctrlStat_t stat;

  seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .stat(stat), .cfg(cfg), .strobe(strobe), .regRdata(regRdata),
    .seqLen(seqLen), .fifoEn(fifoEn), .frzMode(frzMode)
  );

  seq_trig_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .extTrig(extTrig), .seqDone(seqDone),
    .cfg(cfg), .strobe(strobe), .stat(stat),
    .seqStart(seqStart), .seqAbort(seqAbort), .irqOut(irqOut)
  );

endmodule

// File: tb/sim_seq_ctrl_unit.sv
`timescale 1ns/1ps
module sim_seq_ctrl_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       regWe = 1'b0;
  logic [7:0] regRdata;
  logic       extTrig = 1'b0;
  logic       seqDone = 1'b0;
  logic       seqStart, seqAbort, irqOut, fifoEn;
  logic [3:0] seqLen;
  logic [1:0] frzMode;

  int nChecks = 0;
  int nFails  = 0;
  int expQ[$];

  always #2.5 clk = ~clk;

  seq_ctrl_unit u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata), .extTrig(extTrig), .seqDone(seqDone), .seqStart(seqStart),
    .seqAbort(seqAbort), .irqOut(irqOut), .seqLen(seqLen), .fifoEn(fifoEn),
    .frzMode(frzMode)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    #1;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    regAddr = a;
    #0.5;
    v = int'(regRdata);
  endtask

  task automatic pulseDone();
    @(negedge clk); seqDone = 1'b1;
    @(negedge clk); seqDone = 1'b0;
    #1;
  endtask

  task automatic expectStart(input int len);
    expQ.push_back(len);
  endtask

  task automatic drainCheck(input string tag);
    check({tag, " pending starts"}, expQ.size(), 0);
    expQ.delete();
  endtask

  // monitor: every observed start pops one expected item
  initial begin
    forever begin
      @(negedge clk); #1;
      if (seqStart) begin
        if (expQ.size() == 0) check("R1/R2/R9 unexpected start", 1, 0);
        else check("R1/R2 start length", int'(seqLen), expQ.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R6 reset state
    regRead(2'd1, v); check("R6 seq reg reset", v, 8'h20);
    regRead(2'd0, v); check("R6 cfg reg reset", v, 0);
    check("R6 seqLen reset", int'(seqLen), 4);
    check("R6 irq reset", int'(irqOut), 0);
    check("R6 abort reset", int'(seqAbort), 0);

    // R1 rising edge
    regWrite(2'd0, 8'h05);
    expectStart(4);
    extTrig = 1'b1;
    waitCyc(6); drainCheck("R1 rising");
    waitCyc(6); drainCheck("R1 held level no restart");
    pulseDone();
    check("R4 irq masked", int'(irqOut), 0);
    regRead(2'd0, v); check("R3 flag hidden", v, 8'h05);
    regWrite(2'd0, 8'h0D);
    regRead(2'd0, v); check("R3 flag visible", v, 8'h1D);
    check("R4 irq asserted", int'(irqOut), 1);
    regWrite(2'd0, 8'h1D);
    regRead(2'd0, v); check("R5 write one to flag", v, 8'h1D);
    regWrite(2'd0, 8'h0D);
    regRead(2'd0, v); check("R5 write zero to flag", v, 8'h1D);

    // R1 falling edge, R10 clear on start
    regWrite(2'd0, 8'h0C);
    expectStart(4);
    extTrig = 1'b0;
    waitCyc(6); drainCheck("R1 falling");
    check("R10 start clears flag", int'(irqOut), 0);
    pulseDone();
    check("R10 done sets flag", int'(irqOut), 1);

    // R7 R8 sequence register
    regWrite(2'd1, 8'h00);
    check("R9 abort pulse", int'(seqAbort), 1);
    check("R8 zero field", int'(seqLen), 8);
    regRead(2'd1, v); check("R7 readback zero", v, 0);
    waitCyc(1); check("R9 abort one cycle", int'(seqAbort), 0);
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, v); check("R7 bit7 reads zero", v, 8'h7F);
    check("R7 fifo bit", int'(fifoEn), 1);
    check("R7 freeze field", int'(frzMode), 3);
    check("R8 field 15 clamps", int'(seqLen), 8);
    regWrite(2'd1, 8'h48);
    check("R8 field 9 clamps", int'(seqLen), 8);
    regWrite(2'd1, 8'h18);
    check("R8 field 3", int'(seqLen), 3);
    check("R7 fifo off", int'(fifoEn), 0);
    check("R10 flag kept across seq write", int'(irqOut), 1);

    // R9 abort of a running sequence
    regWrite(2'd0, 8'h0D);
    expectStart(3);
    extTrig = 1'b1;
    waitCyc(6); drainCheck("R1 rising len3");
    check("R10 flag cleared by start", int'(irqOut), 0);
    regWrite(2'd1, 8'h28);
    check("R9 abort while running", int'(seqAbort), 1);
    check("R8 field 5", int'(seqLen), 5);
    waitCyc(2);
    pulseDone();
    check("R10 idle done ignored", int'(irqOut), 0);
    extTrig = 1'b0;
    waitCyc(4); drainCheck("R9 no start after abort");
    expectStart(5);
    extTrig = 1'b1;
    waitCyc(6); drainCheck("R9 restart after abort");
    pulseDone();
    check("R4 irq after done", int'(irqOut), 1);

    // R2 level high with back-to-back restart
    extTrig = 1'b0;
    waitCyc(4);
    regWrite(2'd0, 8'h07);
    check("R4 irq disabled", int'(irqOut), 0);
    expectStart(5);
    extTrig = 1'b1;
    waitCyc(6); drainCheck("R2 high level");
    expectStart(5);
    @(negedge clk); seqDone = 1'b1;
    @(negedge clk); seqDone = 1'b0; extTrig = 1'b0;
    waitCyc(4); drainCheck("R2 restart after done");
    pulseDone();
    waitCyc(5); drainCheck("R2 level gone");

    // R2 low level
    expectStart(5);
    regWrite(2'd0, 8'h06);
    waitCyc(4); drainCheck("R2 low level");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule